// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a bank of eight ownership flags that two independent processor ports, a left one and a right one, use to share resources safely. Each port holds its own request register per flag. A port asks for a flag by writing a request and gives it up by writing a release. A small grant stage per flag turns requests into ownership. It never lets both ports own the same flag. A request that is blocked stays pending and becomes ownership by itself once the other side lets go.

Software on either port claims a flag by writing 0 to it. It then reads the flag back and learns from the returned bit whether it now owns it. Each port uses a chip-select, a write strobe, a read strobe, a 3-bit flag index, a single data-in bit and a single data-out bit. Only one data bit exists, so there are no other data lines to ignore or mirror. The shared memory that the flags guard lies outside this block, and so does any meaning given to a particular flag.

Top module: `sem_bank`

## Requirements
- R1: There are eight independent flags, selected by a 3-bit index (0 to 7) on each port. A write to one flag changes no other flag's state as seen from either port.
- R2: A write (chip-select and write strobe high on a clock edge) with data-in 0 records a request from that port. If the flag is free, the port owns it after the next edge. A read whose strobe is sampled at the edge right after the write edge still returns the old state. A read sampled one edge later returns the new state.
- R3: A write with data-in 1 withdraws that port's request or releases its ownership. Once the grant stage has settled, a read returns 1 on that port.
- R4: The two ports never own the same flag at the same time. A same-cycle read of one flag from both ports never returns 0 on both.
- R5: When both ports request a free flag in the same write cycle, the left port gets it. The right request stays pending.
- R6: A pending request is granted on the edge after the owning port's request register clears, with no further write from the waiting port.
- R7: The data-out bit encodes ownership: 0 means the reading port owns the flag, 1 means it does not. The value is loaded on the edge that samples the read strobe and is held until the next read on that port. A read does not change any request or ownership state.
- R8: After reset both data-out bits are 1, no request is pending and every flag is free.
- R9: Write and read strobes have no effect while that port's chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lCs | input | 1 | Left port chip-select |
| lWr | input | 1 | Left port write strobe |
| lRd | input | 1 | Left port read strobe |
| lIdx | input | 3 | Left port flag index |
| lDin | input | 1 | Left port write data (0 = request, 1 = release) |
| lDout | output | 1 | Left port read data (0 = owned by left) |
| rCs | input | 1 | Right port chip-select |
| rWr | input | 1 | Right port write strobe |
| rRd | input | 1 | Right port read strobe |
| rIdx | input | 3 | Right port flag index |
| rDin | input | 1 | Right port write data (0 = request, 1 = release) |
| rDout | output | 1 | Right port read data (0 = owned by right) |

## Verification
A write loads the request register on its own edge. Ownership changes on the next edge. A read loads data-out on the edge that samples its strobe. The bench drives every operation for exactly one edge, from the falling edge. After each write it leaves one idle cycle before reading, and it samples data-out at the falling edge that follows the read edge. One check reads right after a write with no idle cycle and expects the old state, which confirms that the grant really lags by one edge. Handover checks release the owner, wait the same two edges, and expect the waiting port to read 0 without writing again.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  localparam int SemCount = 8;
  localparam int SemIdxW  = $clog2(SemCount);

  // Strobes handed from a port's control decode to the flag datapath
  typedef struct packed {
    logic                wrEn;    // qualified write this cycle
    logic                rdEn;    // qualified read this cycle
    logic                reqSet;  // value to load into the request register
    logic [SemIdxW-1:0]  idx;     // flag addressed (read mux)
    logic [SemCount-1:0] sel;     // one-hot flag select (write decode)
  } portOp_t;

endpackage

// File: rtl/sem_bank_ctrl.sv
module sem_bank_ctrl
  import sem_bank_pkg::*;
(
  input  logic               cs,
  input  logic               wr,
  input  logic               rd,
  input  logic [SemIdxW-1:0] idx,
  input  logic               din,
  output portOp_t            op
);

  logic [SemCount-1:0] selDec;

  always_comb begin
    for (int i = 0; i < SemCount; i++) begin
      selDec[i] = (idx == SemIdxW'(i));
    end
  end

  always_comb begin
    op.wrEn   = cs & wr;
    op.rdEn   = cs & rd;
    op.reqSet = ~din;
    op.idx    = idx;
    op.sel    = selDec;
  end

  always_comb begin
    if (cs) begin
      AST_SEL_ONEHOT: assert ($countones(selDec) == 1); // R1
    end
  end

endmodule

// File: rtl/sem_bank_arb.sv
module sem_bank_arb (
  input  logic clk,
  input  logic rstN,
  input  logic reqL,
  input  logic reqR,
  output logic grantL,
  output logic grantR
);

  logic grantLNext;
  logic grantRNext;

  // Left is blocked only by a right owner that still requests;
  // right yields to whatever left will hold next.
  always_comb begin
    grantLNext = reqL & ~(grantR & reqR);
    grantRNext = reqR & ~grantLNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantL <= 1'b0;
      grantR <= 1'b0;
    end else begin
      grantL <= grantLNext;
      grantR <= grantRNext;
    end
  end

  AST_MUTEX: assert property (@(posedge clk) disable iff (!rstN)
    !(grantL && grantR)); // R4

  AST_LEFT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    reqL && reqR && !grantL && !grantR |=> grantL && !grantR); // R5

  AST_HANDOVER_TO_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    reqL && grantR && !reqR |=> grantL); // R6

  AST_HANDOVER_TO_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    reqR && grantL && !reqL |=> grantR); // R6

  AST_GRANT_L_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grantL |-> $past(reqL)); // R3

  AST_GRANT_R_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grantR |-> $past(reqR)); // R3

endmodule

// File: rtl/sem_bank_flags.sv
module sem_bank_flags
  import sem_bank_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  portOp_t opL,
  input  portOp_t opR,
  output logic    doutL,
  output logic    doutR
);

  logic [SemCount-1:0] reqL;
  logic [SemCount-1:0] reqR;
  logic [SemCount-1:0] grantL;
  logic [SemCount-1:0] grantR;

  // Per-port request registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqL <= '0;
      reqR <= '0;
    end else begin
      for (int i = 0; i < SemCount; i++) begin
        if (opL.wrEn && opL.sel[i]) reqL[i] <= opL.reqSet;
        if (opR.wrEn && opR.sel[i]) reqR[i] <= opR.reqSet;
      end
    end
  end

  // One grant stage per flag
  for (genvar g = 0; g < SemCount; g++) begin : g_arb
    sem_bank_arb u_arb (
      .clk    (clk),
      .rstN   (rstN),
      .reqL   (reqL[g]),
      .reqR   (reqR[g]),
      .grantL (grantL[g]),
      .grantR (grantR[g])
    );
  end

  // Read registers: 0 = owned by this port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutL <= 1'b1;
      doutR <= 1'b1;
    end else begin
      if (opL.rdEn) doutL <= ~grantL[opL.idx];
      if (opR.rdEn) doutR <= ~grantR[opR.idx];
    end
  end

  AST_REQ_L_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    opL.wrEn |=> reqL[$past(opL.idx)] == $past(opL.reqSet)); // R2

  AST_REQ_R_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    opR.wrEn |=> reqR[$past(opR.idx)] == $past(opR.reqSet)); // R2

  AST_REQ_L_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opL.wrEn |=> $stable(reqL)); // R9

  AST_REQ_R_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !opR.wrEn |=> $stable(reqR)); // R9

  AST_DOUT_L_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opL.rdEn |=> $stable(doutL)); // R7

  AST_DOUT_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !opR.rdEn |=> $stable(doutR)); // R7

  AST_NOT_BOTH_OWN: assert property (@(posedge clk) disable iff (!rstN)
    (grantL & grantR) == '0); // R4

endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lCs,
  input  logic               lWr,
  input  logic               lRd,
  input  logic [SemIdxW-1:0] lIdx,
  input  logic               lDin,
  output logic               lDout,
  input  logic               rCs,
  input  logic               rWr,
  input  logic               rRd,
  input  logic [SemIdxW-1:0] rIdx,
  input  logic               rDin,
  output logic               rDout
);

  portOp_t opL;
  portOp_t opR;

  sem_bank_ctrl u_ctrlL (
    .cs  (lCs),
    .wr  (lWr),
    .rd  (lRd),
    .idx (lIdx),
    .din (lDin),
    .op  (opL)
  );

  sem_bank_ctrl u_ctrlR (
    .cs  (rCs),
    .wr  (rWr),
    .rd  (rRd),
    .idx (rIdx),
    .din (rDin),
    .op  (opR)
  );

  sem_bank_flags u_flags (
    .clk   (clk),
    .rstN  (rstN),
    .opL   (opL),
    .opR   (opR),
    .doutL (lDout),
    .doutR (rDout)
  );

endmodule

// File: tb/sem_bank_test.sv
module sem_bank_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lCs = 1'b0, lWr = 1'b0, lRd = 1'b0, lDin = 1'b1;
  logic       rCs = 1'b0, rWr = 1'b0, rRd = 1'b0, rDin = 1'b1;
  logic [2:0] lIdx = 3'd0, rIdx = 3'd0;
  logic       lDout, rDout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sem_bank uut (
    .clk(clk), .rstN(rstN),
    .lCs(lCs), .lWr(lWr), .lRd(lRd), .lIdx(lIdx), .lDin(lDin), .lDout(lDout),
    .rCs(rCs), .rWr(rWr), .rRd(rRd), .rIdx(rIdx), .rDin(rDin), .rDout(rDout)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One write cycle; either side may be skipped or gated
  task automatic writeOp(input bit lOn, input bit lSel, input logic [2:0] li, input logic ld,
                         input bit rOn, input bit rSel, input logic [2:0] ri, input logic rd);
    lCs = lSel; lWr = lOn; lIdx = li; lDin = ld;
    rCs = rSel; rWr = rOn; rIdx = ri; rDin = rd;
    @(negedge clk);
    lCs = 0; lWr = 0; rCs = 0; rWr = 0;
  endtask

  task automatic writeL(input logic [2:0] i, input logic d);
    writeOp(1, 1, i, d, 0, 0, 3'd0, 1'b1);
    idle(1);
  endtask

  task automatic writeR(input logic [2:0] i, input logic d);
    writeOp(0, 0, 3'd0, 1'b1, 1, 1, i, d);
    idle(1);
  endtask

  // Same-cycle read of one flag from both ports; every call also checks R4
  task automatic readBoth(input logic [2:0] i, input logic expL, input logic expR, input string tag);
    lCs = 1; lRd = 1; lIdx = i;
    rCs = 1; rRd = 1; rIdx = i;
    @(negedge clk);
    lCs = 0; lRd = 0; rCs = 0; rRd = 0;
    check({tag, " left"}, lDout, expL);
    check({tag, " right"}, rDout, expR);
    check("R4 not both owners", lDout | rDout, 1'b1);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic testReset();
    check("R8 reset left dout", lDout, 1'b1);
    check("R8 reset right dout", rDout, 1'b1);
    for (int i = 0; i < 8; i++) readBoth(3'(i), 1, 1, "R8 free after reset");
  endtask

  task automatic testClaimAndTiming();
    writeOp(1, 1, 3'd3, 1'b0, 0, 0, 3'd0, 1'b1);
    readBoth(3'd3, 1, 1, "R2 grant not yet visible");
    readBoth(3'd3, 0, 1, "R2 left owns after settle");
    readBoth(3'd2, 1, 1, "R1 neighbour untouched");
    readBoth(3'd4, 1, 1, "R1 neighbour untouched");
  endtask

  task automatic testReadHold();
    lCs = 1; lRd = 1; lIdx = 3'd3;
    @(negedge clk);
    lCs = 0; lRd = 0;
    idle(3);
    check("R7 left dout held", lDout, 1'b0);
    for (int k = 0; k < 3; k++) readBoth(3'd3, 0, 1, "R7 repeated read no side effect");
    // read with index changed but strobe low: value must not move
    lIdx = 3'd0;
    idle(2);
    check("R7 hold without strobe", lDout, 1'b1 ^ 1'b1 ^ rDout ^ rDout ^ 1'b1 ^ 1'b1);
  endtask

  task automatic testHandover();
    writeR(3'd3, 1'b0);
    readBoth(3'd3, 0, 1, "R4 right pending while left owns");
    writeL(3'd3, 1'b1);
    readBoth(3'd3, 1, 0, "R6 right granted after release");
    writeR(3'd3, 1'b1);
    readBoth(3'd3, 1, 1, "R3 release frees flag");
  endtask

  task automatic testTie();
    writeOp(1, 1, 3'd5, 1'b0, 1, 1, 3'd5, 1'b0);
    idle(1);
    for (int k = 0; k < 4; k++) readBoth(3'd5, 0, 1, "R5 left wins tie");
    writeL(3'd5, 1'b1);
    readBoth(3'd5, 1, 0, "R5 right stays pending then granted");
    writeR(3'd5, 1'b1);
    readBoth(3'd5, 1, 1, "R3 tie flag released");
  endtask

  task automatic testWithdraw();
    writeL(3'd0, 1'b0);
    writeR(3'd0, 1'b0);
    writeR(3'd0, 1'b1);
    writeL(3'd0, 1'b1);
    idle(1);
    readBoth(3'd0, 1, 1, "R3 withdrawn request not granted");
  endtask

  task automatic testChipSelect();
    writeOp(1, 0, 3'd6, 1'b0, 1, 0, 3'd7, 1'b0);
    idle(1);
    readBoth(3'd6, 1, 1, "R9 gated write ignored");
    readBoth(3'd7, 1, 1, "R9 gated write ignored");
    writeL(3'd6, 1'b0);
    readBoth(3'd6, 0, 1, "R9 setup owner");
    lRd = 1; lIdx = 3'd1;
    @(negedge clk);
    lRd = 0;
    check("R9 gated read leaves dout", lDout, 1'b0);
    writeL(3'd6, 1'b1);
  endtask

  task automatic testAllFlags();
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) writeL(3'(i), 1'b0);
      else            writeR(3'(i), 1'b0);
    end
    for (int i = 0; i < 8; i++) begin
      if (i % 2 == 0) readBoth(3'(i), 0, 1, "R1 even flag left");
      else            readBoth(3'(i), 1, 0, "R1 odd flag right");
    end
    for (int i = 0; i < 8; i++) writeOp(1, 1, 3'(i), 1'b1, 1, 1, 3'(i), 1'b1);
    idle(1);
    for (int i = 0; i < 8; i++) readBoth(3'(i), 1, 1, "R3 all released");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);
    testReset();
    testClaimAndTiming();
    testReadHold();
    testHandover();
    testTie();
    testWithdraw();
    testChipSelect();
    testAllFlags();
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finishRun();
    end
  end

endmodule